// File: doc/BRIEF.md
# Carrier Activity Status Serializer

This block watches the carrier-sense signals of nine ports (one attachment-unit port and eight twisted-pair ports) and reports their recent activity as one continuous serial bit stream on a single output pin, clocked by the system clock. Time is cut into fixed measurement windows counted in clock cycles. During a window, each port has a sticky latch that records whether its carrier input was high in any cycle, however short the burst.

At each window boundary the latches are copied into a status register and cleared in the same cycle. The status register then holds for the whole following window, so a single-cycle burst is reported for one full window. A serializer sends the status as fixed 16-bit frames, back to back with no gap. Each frame is a start bit of 1, then the nine port bits (port 0, the attachment-unit port, first), then six idle zeros. A new status value is taken into the serializer only at a frame boundary, so no frame mixes bits from two windows.

Top module: `carrier_status_serializer`

## Requirements
- R1: A window boundary occurs once every WINDOW_CYCLES clock cycles, counted from the release of reset. The default is 40,000 cycles, which is 2 ms at 20 MHz.
- R2: A carrier input that is high for even a single cycle inside a window sets that port's latch, and the latch stays set until the next boundary.
- R3: In the cycle after a boundary, the status register takes the latch contents. It then holds that value unchanged for the whole of the next window.
- R4: Carrier activity in the boundary cycle itself belongs to the new window. It appears in the status only after the following boundary.
- R5: The output is a repeating 16-bit frame: frame bit 0 is a start bit of 1, frame bits 1 to 9 carry ports 0 to 8 in that order, and frame bits 10 to 15 are 0. Frames follow one another without a gap.
- R6: The port bits of a frame all come from one status value, taken at the last bit of the previous frame.
- R7: A synchronous active-high reset clears the latches, the status register, the window counter and the frame position. After reset the output sends frames that have only the start bit set.
- R8: A port with no carrier activity in a window reports 0 in its frame position during the next window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| carrier_in | input | NUM_PORTS | Per-port carrier sense, bit 0 is the attachment-unit port |
| status_out | output | 1 | Serial status stream, one bit per clock |

## Verification
The assertions assume that carrier_in is synchronous to clk and free of unknown values. They also assume that reset is held for at least one clock edge before the first checked cycle. The window-stability and snapshot-hold properties are only meaningful once reset has been released, so each property is disabled while rst is high. The bench drives carrier_in and rst only at falling edges, from one sequential process, so every input is settled well before the rising edge that samples it. Its stimulus includes a pulse placed exactly in the boundary cycle and a reset applied in the middle of a frame.

// File: rtl/cs_ser_pkg.sv
package cs_ser_pkg;
    localparam int unsigned PORTS_DEFAULT  = 9;
    localparam int unsigned FRAME_DEFAULT  = 16;
    localparam int unsigned WINDOW_DEFAULT = 40000;
    localparam logic        START_LEVEL    = 1'b1;
endpackage

// File: rtl/cs_window_timer.sv
module cs_window_timer #(
    parameter int unsigned WINDOW_CYCLES = 40000
) (
    input  logic clk,
    input  logic rst,
    output logic win_end
);
    localparam int unsigned CW = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } timer_t;

    timer_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.cnt == LAST) nxt_d.cnt = '0;
        else                   nxt_d.cnt = cur_q.cnt + 1'b1;
        if (rst) nxt_d = '0;
    end

    always_ff @(posedge clk) cur_q <= nxt_d;

    assign win_end = (cur_q.cnt == LAST);
endmodule

// File: rtl/cs_activity_capture.sv
module cs_activity_capture #(
    parameter int unsigned NUM_PORTS = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 win_end,
    input  logic [NUM_PORTS-1:0] carrier_in,
    output logic [NUM_PORTS-1:0] latch_q,
    output logic [NUM_PORTS-1:0] status_q
);
    typedef struct packed {
        logic [NUM_PORTS-1:0] latch;
        logic [NUM_PORTS-1:0] status;
    } capt_t;

    capt_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (win_end) begin
            nxt_d.status = cur_q.latch;
            nxt_d.latch  = carrier_in;
        end else begin
            nxt_d.latch  = cur_q.latch | carrier_in;
        end
        if (rst) nxt_d = '0;
    end

    always_ff @(posedge clk) cur_q <= nxt_d;

    assign latch_q  = cur_q.latch;
    assign status_q = cur_q.status;
endmodule

// File: rtl/cs_frame_shifter.sv
module cs_frame_shifter #(
    parameter int unsigned NUM_PORTS = 9,
    parameter int unsigned FRAME_LEN = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_PORTS-1:0]         status_in,
    output logic [$clog2(FRAME_LEN)-1:0] pos_q,
    output logic [NUM_PORTS-1:0]         snap_q,
    output logic                         ser_out
);
    localparam int unsigned PW = $clog2(FRAME_LEN);
    localparam logic [PW-1:0] LAST_POS = PW'(FRAME_LEN - 1);

    typedef struct packed {
        logic [PW-1:0]        pos;
        logic [NUM_PORTS-1:0] snap;
    } shf_t;

    shf_t cur_q, nxt_d;
    logic [FRAME_LEN-1:0] frame_vec;

    assign frame_vec[0] = cs_ser_pkg::START_LEVEL;
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port_bits
        assign frame_vec[i+1] = cur_q.snap[i];
    end
    for (genvar j = NUM_PORTS + 1; j < FRAME_LEN; j++) begin : g_idle_bits
        assign frame_vec[j] = 1'b0;
    end

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.pos == LAST_POS) begin
            nxt_d.pos  = '0;
            nxt_d.snap = status_in;
        end else begin
            nxt_d.pos  = cur_q.pos + 1'b1;
        end
        if (rst) nxt_d = '0;
    end

    always_ff @(posedge clk) cur_q <= nxt_d;

    assign ser_out = frame_vec[cur_q.pos];
    assign pos_q   = cur_q.pos;
    assign snap_q  = cur_q.snap;
endmodule

// File: rtl/carrier_status_serializer.sv
module carrier_status_serializer #(
    parameter int unsigned WINDOW_CYCLES = cs_ser_pkg::WINDOW_DEFAULT,
    parameter int unsigned NUM_PORTS     = cs_ser_pkg::PORTS_DEFAULT,
    parameter int unsigned FRAME_LEN     = cs_ser_pkg::FRAME_DEFAULT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PORTS-1:0] carrier_in,
    output logic                 status_out
);
    localparam int unsigned PW = $clog2(FRAME_LEN);

    logic                 win_end;
    logic [NUM_PORTS-1:0] latch_q;
    logic [NUM_PORTS-1:0] status_q;
    logic [PW-1:0]        pos_q;
    logic [NUM_PORTS-1:0] snap_q;

    cs_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .win_end (win_end)
    );

    cs_activity_capture #(.NUM_PORTS(NUM_PORTS)) u_capture (
        .clk        (clk),
        .rst        (rst),
        .win_end    (win_end),
        .carrier_in (carrier_in),
        .latch_q    (latch_q),
        .status_q   (status_q)
    );

    cs_frame_shifter #(.NUM_PORTS(NUM_PORTS), .FRAME_LEN(FRAME_LEN)) u_shifter (
        .clk       (clk),
        .rst       (rst),
        .status_in (status_q),
        .pos_q     (pos_q),
        .snap_q    (snap_q),
        .ser_out   (status_out)
    );
endmodule

// File: rtl/carrier_status_serializer_chk.sv
module carrier_status_serializer_chk #(
    parameter int unsigned NUM_PORTS = 9,
    parameter int unsigned FRAME_LEN = 16
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         status_out,
    input logic                         win_end,
    input logic [NUM_PORTS-1:0]         latch_q,
    input logic [NUM_PORTS-1:0]         status_q,
    input logic [$clog2(FRAME_LEN)-1:0] pos_q,
    input logic [NUM_PORTS-1:0]         snap_q
);
    logic rst_seen_q;
    always_ff @(posedge clk) rst_seen_q <= rst;

    // R7: everything cleared in the cycle after reset
    always_ff @(posedge clk) begin
        if (rst_seen_q) begin
            a_reset_clear_r7: assert (latch_q == '0 && status_q == '0 && pos_q == '0 && snap_q == '0)
                else $error("reset did not clear state");
        end
    end

    p_win_gap_r1: assert property (@(posedge clk) disable iff (rst)
        win_end |=> !win_end);

    p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        !win_end |=> ((latch_q & $past(latch_q)) == $past(latch_q)));

    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        win_end |=> (status_q == $past(latch_q)));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !win_end |=> $stable(status_q));

    p_start_bit_r5: assert property (@(posedge clk) disable iff (rst)
        (pos_q == '0) |-> status_out);

    p_idle_bits_r5: assert property (@(posedge clk) disable iff (rst)
        (32'(pos_q) > NUM_PORTS) |-> !status_out);

    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (32'(pos_q) == FRAME_LEN - 1) |=> (pos_q == '0));

    p_snap_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (32'(pos_q) != FRAME_LEN - 1) |=> $stable(snap_q));
endmodule

bind carrier_status_serializer carrier_status_serializer_chk #(
    .NUM_PORTS(NUM_PORTS),
    .FRAME_LEN(FRAME_LEN)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .status_out (status_out),
    .win_end    (win_end),
    .latch_q    (latch_q),
    .status_q   (status_q),
    .pos_q      (pos_q),
    .snap_q     (snap_q)
);

// File: tb/test_carrier_status_serializer.sv
module test_carrier_status_serializer;
    localparam int W  = 40;
    localparam int NP = 9;
    localparam int FL = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] carrier = '0;
    logic          status_out;

    int n_cmp = 0;
    int n_bad = 0;
    string req_tag = "R7";

    // behavioural reference state
    int        m_cnt, m_pos;
    bit [NP-1:0] m_latch, m_status, m_snap;
    int        n_cnt, n_pos;
    bit [NP-1:0] n_latch, n_status, n_snap;
    bit        m_valid = 1'b0;

    always #2.5 clk = ~clk;

    carrier_status_serializer #(.WINDOW_CYCLES(W), .NUM_PORTS(NP), .FRAME_LEN(FL)) i_carrier_status_serializer (
        .clk        (clk),
        .rst        (rst),
        .carrier_in (carrier),
        .status_out (status_out)
    );

    function automatic bit exp_bit();
        if (m_pos == 0) return 1'b1;
        if (m_pos <= NP) return m_snap[m_pos-1];
        return 1'b0;
    endfunction

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic compare(input string tag, input bit act, input bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: status_out=%b expected=%b (frame bit %0d)", tag, $time, act, exp, m_pos);
        end
    endtask

    task automatic cyc(input logic [NP-1:0] c, input logic r);
        @(negedge clk);
        if (m_valid) compare(req_tag, status_out, exp_bit());
        carrier = c;
        rst     = r;
        if (r) begin
            n_cnt = 0; n_pos = 0; n_latch = '0; n_status = '0; n_snap = '0;
        end else begin
            n_cnt    = (m_cnt == W - 1) ? 0 : m_cnt + 1;
            n_status = (m_cnt == W - 1) ? m_latch : m_status;
            n_latch  = (m_cnt == W - 1) ? bit'(1) * c : (m_latch | c);
            n_pos    = (m_pos == FL - 1) ? 0 : m_pos + 1;
            n_snap   = (m_pos == FL - 1) ? m_status : m_snap;
        end
        @(posedge clk);
        m_cnt = n_cnt; m_pos = n_pos; m_latch = n_latch;
        m_status = n_status; m_snap = n_snap;
        if (r) m_valid = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc('0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
        finish_run();
    end

    initial begin
        // R7: reset state, start bit only
        req_tag = "R7";
        for (int i = 0; i < 3; i++) cyc('0, 1'b1);
        @(negedge clk);
        compare("R7 start bit after reset", status_out, 1'b1);
        idle(20);

        // R8: nothing active, only start bits
        req_tag = "R8";
        idle(100);

        // R2: single-cycle pulse on port 0 mid-window
        req_tag = "R2";
        idle(10);
        cyc(9'h001, 1'b0);
        idle(130);

        // R3: pulse on port 8, held report for full window
        req_tag = "R3";
        cyc(9'h100, 1'b0);
        idle(130);

        // R5: every port active for a long stretch
        req_tag = "R5";
        for (int i = 0; i < 90; i++) cyc('1, 1'b0);
        idle(130);

        // R4: pulse placed exactly on the boundary cycle
        req_tag = "R4";
        while (m_cnt != W - 1) cyc('0, 1'b0);
        cyc(9'h010, 1'b0);
        idle(130);

        // R6: alternating patterns so windows change mid-frame
        req_tag = "R6";
        for (int k = 0; k < 8; k++) begin
            cyc(9'(9'h0AA >> (k % 2)), 1'b0);
            idle(27);
        end
        idle(100);

        // R1: steady carrier on port 2 across many windows
        req_tag = "R1";
        for (int i = 0; i < 200; i++) cyc(9'h004, 1'b0);
        idle(100);

        // R7: reset in the middle of a frame with activity latched
        req_tag = "R7";
        for (int i = 0; i < 7; i++) cyc(9'h1FF, 1'b0);
        cyc('0, 1'b1);
        @(negedge clk);
        compare("R7 mid-run reset start bit", status_out, 1'b1);
        idle(120);

        finish_run();
    end
endmodule